// File: doc/BRIEF.md
# ISDN Basic-Rate Layer-1 Activation Controller

This block runs the terminal-side activation procedure of an ISDN basic-rate line. The line transceiver reports the line condition as a 4-bit indication code together with a change-valid strobe. The upper layer can ask for activation or deactivation. An internal supervision timer bounds how long an activation attempt may run. From these events the block follows a fixed nine-state table. It sends 4-bit command codes back to the transceiver, packed into a command byte, and pulses activate or deactivate indications towards the upper layer.

A `link_active` status is high only in the active state F7. Data transmission elsewhere in the chip is gated on it. Two transceiver variants place the command field at different bit positions, and the `CMD_LAYOUT` parameter selects the packing at elaboration time. At most one event is taken per clock cycle. A fixed priority decides which one, and the losing events of that cycle are discarded.

State encoding on `l1_state`: 0 reset, 1 F3 power-down, 2 F3 power-up, 3 F3 pending-deactivation, 4 F4, 5 F5, 6 F6, 7 F7 (active), 8 F8.

Top module: `l1act_ctrl`

## Requirements
- R1: After reset, `l1_state` is 0 (reset state), `link_active` is 0, and `cmd_valid`, `act_ind` and `deact_ind` are 0.
- R2: `ind_code` is only taken in a cycle where `ind_valid` is 1. A code presented without the strobe changes nothing.
- R3: Indication code 0001 (line reset) or code 0110 (error) moves every state to the reset state and issues command 1111 (deactivate). From F7 it also pulses `deact_ind`.
- R4: Indication code 1100 (activation at priority 8) takes reset, F3 power-down, F3 pending, F4, F5, F6 or F8 to F7. It issues command 1000 (activate at priority 8), pulses `act_ind`, stops the supervision timer and raises `link_active`.
- R5: An activate request in F3 power-down issues command 1000 and (re)starts the supervision timer, leaving the state unchanged. In any other state it has no effect. A deactivate request never has an effect.
- R6: The supervision timer expires `TIMER_CYCLES` cycles after the edge that started it. In F3 power-down, F4, F5, F6 or F8, expiry issues command 1111 and pulses `deact_ind` without a state change. In other states it has no effect, and it fires at most once per start.
- R7: Indication code 1111 (deactivation confirmed) moves reset, F3 pending, F4, F5, F6 and F8 to F3 power-down. It issues no command.
- R8: Indication code 1000 (activation request from the line) moves reset, F3 power-down, F3 pending, F5 and F8 to F6. Code 0100 (resynchronising) moves F3 power-down, F3 pending and F4 to F5, and moves F6 to F8. Code 0111 (power up) moves F3 power-down to F4. None of these issues a command.
- R9: Code 0000 (deactivation request from the line) in F5 or F8, and code 0101 in F6, move to F3 pending and issue command 1111.
- R10: From F7, code 1000 goes to F6 and code 0100 goes to F8, with no command. Code 0000 goes to F3 pending with command 1111. Each of these pulses `deact_ind`.
- R11: Any indication not listed for the current state is ignored: no state change, no command and no indication.
- R12: With `CMD_LAYOUT`=0, `cmd_byte` is {2'b00, code, 2'b11}. With `CMD_LAYOUT`=1, it is {code, 4'b1110}. The command codes are 0000 timing, 0001 reset, 1000 activate-8, 1001 activate-10, 1010 activate-loop and 1111 deactivate.
- R13: When events fall in the same cycle, the strobed indication wins over timer expiry, expiry wins over the activate request, and the activate request wins over the deactivate request. Losing events are discarded.
- R14: `cmd_valid`, `act_ind` and `deact_ind` are single-cycle pulses registered on the edge that samples the event. `act_ind` and `deact_ind` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_valid | input | 1 | Change-valid strobe for `ind_code` |
| ind_code | input | 4 | Line indication code from the transceiver |
| act_req | input | 1 | Activate request from the upper layer |
| deact_req | input | 1 | Deactivate request from the upper layer |
| cmd_valid | output | 1 | Command byte is to be written this cycle |
| cmd_byte | output | 8 | Packed command byte for the transceiver |
| act_ind | output | 1 | Activate indication pulse to the upper layer |
| deact_ind | output | 1 | Deactivate indication pulse to the upper layer |
| link_active | output | 1 | High while the state is F7 |
| l1_state | output | 4 | Current activation state |

## Verification
Two pairs of functions can fall in the same cycle: timer expiry with a strobed indication, and timer expiry with a new activate request. The bench counts cycles from the activate request and drives the competing event on exactly the edge where the timer runs out. A resynchronising indication in F4 must move the state to F5 with no deactivate pulse, then or later. A second activate request must produce only the expiry's deactivate command and indication, with no further expiry afterwards. An activate request strobed together with a power-up indication must yield F4 with no command and no timer.

// File: rtl/l1act_pkg.sv
package l1act_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [3:0] {
      ST_RESET   = 4'd0,
      ST_F3_DOWN = 4'd1,
      ST_F3_UP   = 4'd2,
      ST_F3_PEND = 4'd3,
      ST_F4      = 4'd4,
      ST_F5      = 4'd5,
      ST_F6      = 4'd6,
      ST_F7      = 4'd7,
      ST_F8      = 4'd8
   } l1_state_e;

   // line indication codes; numeric values are decoded by the transceiver
   typedef enum logic [3:0] {
      IND_DEACT      = 4'b0000,
      IND_RESET      = 4'b0001,
      IND_TEST       = 4'b0010,
      IND_SLIP       = 4'b0011,
      IND_RESYNC     = 4'b0100,
      IND_DEACT_F6   = 4'b0101,
      IND_ERROR      = 4'b0110,
      IND_POWER_UP   = 4'b0111,
      IND_ACT_REQ    = 4'b1000,
      IND_SPARE9     = 4'b1001,
      IND_ACT_LOOP   = 4'b1010,
      IND_CODE_VIOL  = 4'b1011,
      IND_ACT8       = 4'b1100,
      IND_ACT10      = 4'b1101,
      IND_ACT_LOOPED = 4'b1110,
      IND_DEACT_CONF = 4'b1111
   } ind_code_e;

   localparam logic [CODE_W-1:0] CMD_TIMING   = 4'b0000;
   localparam logic [CODE_W-1:0] CMD_RESET    = 4'b0001;
   localparam logic [CODE_W-1:0] CMD_ACT8     = 4'b1000;
   localparam logic [CODE_W-1:0] CMD_ACT10    = 4'b1001;
   localparam logic [CODE_W-1:0] CMD_ACT_LOOP = 4'b1010;
   localparam logic [CODE_W-1:0] CMD_DEACT    = 4'b1111;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_LINE,
      EV_EXPIRE,
      EV_ACTREQ,
      EV_DEACTREQ
   } ev_kind_e;

   typedef struct packed {
      l1_state_e         nxt;
      logic              cmd_en;
      logic [CODE_W-1:0] cmd;
      logic              act;
      logic              deact;
      logic              t_start;
      logic              t_stop;
   } step_t;

endpackage

// File: rtl/l1act_timer.sv
module l1act_timer #(
   parameter int TICKS = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic expire,
   output logic running
);

   localparam int CW = $clog2(TICKS + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      a_cfg_ticks : assert (TICKS >= 2)
         else $error("l1act_timer: TICKS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (stop) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(TICKS);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire  = (cnt_q == CW'(1));
   assign running = (cnt_q != '0);

   // R6: one start yields a single expiry cycle
   p_single_expiry_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   // R4: a stop leaves the timer idle
   p_stop_idles_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !running);

endmodule

// File: rtl/l1act_step.sv
module l1act_step
   import l1act_pkg::*;
(
   input  l1_state_e         st,
   input  ev_kind_e          kind,
   input  logic [CODE_W-1:0] code,
   output step_t             res
);

   always_comb begin
      res     = '0;
      res.nxt = st;
      unique case (kind)
         EV_LINE: begin
            unique case (ind_code_e'(code))
               IND_RESET, IND_ERROR: begin
                  res.nxt    = ST_RESET;
                  res.cmd_en = 1'b1;
                  res.cmd    = CMD_DEACT;
                  res.deact  = (st == ST_F7);
               end
               IND_ACT8: begin
                  if (st != ST_F7 && st != ST_F3_UP) begin
                     res.nxt    = ST_F7;
                     res.cmd_en = 1'b1;
                     res.cmd    = CMD_ACT8;
                     res.act    = 1'b1;
                     res.t_stop = 1'b1;
                  end
               end
               IND_DEACT_CONF: begin
                  if (st inside {ST_RESET, ST_F3_PEND, ST_F4, ST_F5, ST_F6, ST_F8})
                     res.nxt = ST_F3_DOWN;
               end
               IND_ACT_REQ: begin
                  if (st inside {ST_RESET, ST_F3_DOWN, ST_F3_PEND, ST_F5, ST_F8}) begin
                     res.nxt = ST_F6;
                  end else if (st == ST_F7) begin
                     res.nxt   = ST_F6;
                     res.deact = 1'b1;
                  end
               end
               IND_RESYNC: begin
                  if (st inside {ST_F3_DOWN, ST_F3_PEND, ST_F4}) begin
                     res.nxt = ST_F5;
                  end else if (st == ST_F6) begin
                     res.nxt = ST_F8;
                  end else if (st == ST_F7) begin
                     res.nxt   = ST_F8;
                     res.deact = 1'b1;
                  end
               end
               IND_POWER_UP: begin
                  if (st == ST_F3_DOWN)
                     res.nxt = ST_F4;
               end
               IND_DEACT: begin
                  if (st inside {ST_F5, ST_F7, ST_F8}) begin
                     res.nxt    = ST_F3_PEND;
                     res.cmd_en = 1'b1;
                     res.cmd    = CMD_DEACT;
                     res.deact  = (st == ST_F7);
                  end
               end
               IND_DEACT_F6: begin
                  if (st == ST_F6) begin
                     res.nxt    = ST_F3_PEND;
                     res.cmd_en = 1'b1;
                     res.cmd    = CMD_DEACT;
                  end
               end
               default: ;
            endcase
         end
         EV_EXPIRE: begin
            if (st inside {ST_F3_DOWN, ST_F4, ST_F5, ST_F6, ST_F8}) begin
               res.cmd_en = 1'b1;
               res.cmd    = CMD_DEACT;
               res.deact  = 1'b1;
            end
         end
         EV_ACTREQ: begin
            if (st == ST_F3_DOWN) begin
               res.cmd_en  = 1'b1;
               res.cmd     = CMD_ACT8;
               res.t_start = 1'b1;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/l1act_cmdpack.sv
module l1act_cmdpack
   import l1act_pkg::*;
#(
   parameter int LAYOUT = 0
) (
   input  logic [CODE_W-1:0] code,
   output logic [7:0]        byte_o
);

   initial begin
      a_cfg_layout : assert (LAYOUT == 0 || LAYOUT == 1)
         else $error("l1act_cmdpack: LAYOUT must be 0 or 1");
   end

   generate
      if (LAYOUT == 0) begin : g_low_field
         assign byte_o = {2'b00, code, 2'b11};
      end else begin : g_high_field
         assign byte_o = {code, 4'b1110};
      end
   endgenerate

endmodule

// File: rtl/l1act_ctrl.sv
module l1act_ctrl
   import l1act_pkg::*;
#(
   parameter int TIMER_CYCLES = 4000,
   parameter int CMD_LAYOUT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ind_valid,
   input  logic [CODE_W-1:0] ind_code,
   input  logic              act_req,
   input  logic              deact_req,
   output logic              cmd_valid,
   output logic [7:0]        cmd_byte,
   output logic              act_ind,
   output logic              deact_ind,
   output logic              link_active,
   output logic [3:0]        l1_state
);

   l1_state_e         state_q;
   logic              cmd_valid_q;
   logic [CODE_W-1:0] cmd_code_q;
   logic              act_q;
   logic              deact_q;
   ev_kind_e          kind;
   step_t             step;
   logic              tmr_expire;
   logic              tmr_running;

   initial begin
      a_cfg_top : assert (TIMER_CYCLES >= 2 && (CMD_LAYOUT == 0 || CMD_LAYOUT == 1))
         else $error("l1act_ctrl: bad parameter set");
   end

   // R13: one event per cycle, fixed priority
   always_comb begin
      if (ind_valid)       kind = EV_LINE;
      else if (tmr_expire) kind = EV_EXPIRE;
      else if (act_req)    kind = EV_ACTREQ;
      else if (deact_req)  kind = EV_DEACTREQ;
      else                 kind = EV_NONE;
   end

   l1act_step u_step (
      .st   (state_q),
      .kind (kind),
      .code (ind_code),
      .res  (step)
   );

   l1act_timer #(.TICKS(TIMER_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (step.t_start),
      .stop    (step.t_stop),
      .expire  (tmr_expire),
      .running (tmr_running)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RESET;
         cmd_valid_q <= 1'b0;
         cmd_code_q  <= CMD_TIMING;
         act_q       <= 1'b0;
         deact_q     <= 1'b0;
      end else begin
         state_q     <= step.nxt;
         cmd_valid_q <= step.cmd_en;
         if (step.cmd_en)
            cmd_code_q <= step.cmd;
         act_q       <= step.act;
         deact_q     <= step.deact;
      end
   end

   l1act_cmdpack #(.LAYOUT(CMD_LAYOUT)) u_pack (
      .code   (cmd_code_q),
      .byte_o (cmd_byte)
   );

   assign cmd_valid   = cmd_valid_q;
   assign act_ind     = act_q;
   assign deact_ind   = deact_q;
   assign link_active = (state_q == ST_F7);
   assign l1_state    = state_q;

   // R4: activation pulse comes with the active state and the activate command
   p_act_enters_f7_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      act_ind |-> (link_active && cmd_valid && cmd_code_q == CMD_ACT8));

   // R4: the supervision timer never runs while active
   p_timer_idle_active_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      link_active |-> !tmr_running);

   // R10: every exit from F7 is reported upward
   p_leave_f7_reported_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_active) |-> deact_ind);

   // R14: the two upward pulses never coincide
   p_ind_exclusive_r14 : assert property (@(posedge clk) disable iff (!rst_n)
      !(act_ind && deact_ind));

   // R11: the test-mode code is ignored in every state
   p_test_code_ignored_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (ind_valid && ind_code == IND_TEST) |=> ($stable(state_q) && !cmd_valid && !act_ind && !deact_ind));

   // R2 R5: without a strobe, expiry or activate request nothing moves
   p_quiet_stays_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ind_valid && !tmr_expire && !act_req) |=> ($stable(state_q) && !cmd_valid));

endmodule

// File: tb/test_l1act_ctrl.sv
`timescale 1ns/1ps
module test_l1act_ctrl;

   localparam int T = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ind_valid = 1'b0;
   logic [3:0] ind_code = 4'd0;
   logic       act_req = 1'b0;
   logic       deact_req = 1'b0;

   logic       cmd_valid, cmd_valid_b;
   logic [7:0] cmd_byte, cmd_byte_b;
   logic       act_ind, act_ind_b, deact_ind, deact_ind_b;
   logic       link_active, link_active_b;
   logic [3:0] l1_state, l1_state_b;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   l1act_ctrl #(.TIMER_CYCLES(T), .CMD_LAYOUT(0)) i_l1act_ctrl (
      .clk(clk), .rst_n(rst_n), .ind_valid(ind_valid), .ind_code(ind_code),
      .act_req(act_req), .deact_req(deact_req), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .act_ind(act_ind), .deact_ind(deact_ind),
      .link_active(link_active), .l1_state(l1_state));

   l1act_ctrl #(.TIMER_CYCLES(T), .CMD_LAYOUT(1)) i_l1act_ctrl_b (
      .clk(clk), .rst_n(rst_n), .ind_valid(ind_valid), .ind_code(ind_code),
      .act_req(act_req), .deact_req(deact_req), .cmd_valid(cmd_valid_b),
      .cmd_byte(cmd_byte_b), .act_ind(act_ind_b), .deact_ind(deact_ind_b),
      .link_active(link_active_b), .l1_state(l1_state_b));

   // expected {next state, cmd valid, cmd code, act, deact} for state s, code c
   function automatic logic [10:0] model(input int s, input int c);
      int n = s;
      bit cv = 1'b0;
      int cd = 0;
      bit a = 1'b0;
      bit d = 1'b0;
      case (c)
         1, 6: begin n = 0; cv = 1; cd = 15; d = (s == 7); end
         12: if (s != 7 && s != 2) begin n = 7; cv = 1; cd = 8; a = 1; end
         15: if (s == 0 || s == 3 || s == 4 || s == 5 || s == 6 || s == 8) n = 1;
         8: begin
            if (s == 0 || s == 1 || s == 3 || s == 5 || s == 8) n = 6;
            else if (s == 7) begin n = 6; d = 1; end
         end
         4: begin
            if (s == 1 || s == 3 || s == 4) n = 5;
            else if (s == 6) n = 8;
            else if (s == 7) begin n = 8; d = 1; end
         end
         7: if (s == 1) n = 4;
         0: if (s == 5 || s == 8 || s == 7) begin n = 3; cv = 1; cd = 15; d = (s == 7); end
         5: if (s == 6) begin n = 3; cv = 1; cd = 15; end
         default: ;
      endcase
      return {4'(n), cv, 4'(cd), a, d};
   endfunction

   function automatic string tag_of(input int s, input int c);
      case (c)
         1, 6:    return "R3";
         12:      return "R4";
         15:      return "R7";
         8, 4, 7: return (s == 7) ? "R10" : "R8";
         0, 5:    return (s == 7) ? "R10" : "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input int es, input bit ecv,
                      input int ecode, input bit ea, input bit ed);
      logic [7:0] eb0, eb1;
      bit ok;
      eb0 = {2'b00, 4'(ecode), 2'b11};   // R12 layout 0
      eb1 = {4'(ecode), 4'b1110};        // R12 layout 1
      ok = (l1_state == 4'(es)) && (l1_state_b == 4'(es)) &&
           (cmd_valid == ecv) && (cmd_valid_b == ecv) &&
           (!ecv || (cmd_byte == eb0 && cmd_byte_b == eb1)) &&
           (act_ind == ea) && (act_ind_b == ea) &&
           (deact_ind == ed) && (deact_ind_b == ed) &&
           (link_active == (es == 7)) && (link_active_b == (es == 7));
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual st=%0d cv=%0b byte=%h/%h act=%0b deact=%0b link=%0b expected st=%0d cv=%0b byte=%h/%h act=%0b deact=%0b link=%0b",
                  tag, l1_state, cmd_valid, cmd_byte, cmd_byte_b, act_ind, deact_ind, link_active,
                  es, ecv, eb0, eb1, ea, ed, (es == 7));
      end
   endtask

   task automatic quiet(input int n, input string tag);
      bit bad = 1'b0;
      logic [3:0] snap = 4'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!bad && (cmd_valid || cmd_valid_b || act_ind || deact_ind || act_ind_b || deact_ind_b)) begin
            bad = 1'b1;
            snap = {cmd_valid, act_ind, deact_ind, cmd_valid_b};
         end
      end
      checks++;
      if (bad) begin
         failures++;
         $display("FAIL %s: actual pulses {cv,act,deact,cv_b}=%b expected 0000", tag, snap);
      end
   endtask

   task automatic do_reset();
      ind_valid = 1'b0; act_req = 1'b0; deact_req = 1'b0; ind_code = 4'd0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic step_ind(input int c);
      ind_valid = 1'b1;
      ind_code  = 4'(c);
      @(negedge clk);
      ind_valid = 1'b0;
   endtask

   task automatic act_pulse();
      act_req = 1'b1;
      @(negedge clk);
      act_req = 1'b0;
   endtask

   task automatic goto_state(input int s);
      do_reset();
      case (s)
         1: step_ind(15);
         3: begin step_ind(8); step_ind(5); end
         4: begin step_ind(15); step_ind(7); end
         5: begin step_ind(15); step_ind(4); end
         6: step_ind(8);
         7: step_ind(12);
         8: begin step_ind(8); step_ind(4); end
         default: ;
      endcase
   endtask

   // R6: arm in F3 power-down, move to target, watch the expiry edge
   task automatic tmr_case(input int target, input bit fire);
      int k = 0;
      do_reset();
      step_ind(15);
      act_pulse();
      chk("R5 act request in F3 power-down", 1, 1, 8, 0, 0);
      case (target)
         4: begin step_ind(7); k = 1; end
         5: begin step_ind(4); k = 1; end
         6: begin step_ind(8); k = 1; end
         8: begin step_ind(8); step_ind(4); k = 2; end
         3: begin step_ind(8); step_ind(5); k = 2; end
         7: begin step_ind(12); k = 1; end
         0: begin step_ind(1); k = 1; end
         default: ;
      endcase
      quiet(T - 1 - k, "R6 before expiry");
      @(negedge clk);
      if (fire) chk("R6 expiry", target, 1, 15, 0, 1);
      else      chk("R6 expiry ignored", target, 0, 0, 0, 0);
      quiet(T, "R6 no second expiry");
   endtask

   initial begin
      int st_list[8] = '{0, 1, 3, 4, 5, 6, 7, 8};
      logic [10:0] e;

      do_reset();
      chk("R1 reset state", 0, 0, 0, 0, 0);
      quiet(3, "R1 idle after reset");

      // R2: code without strobe
      goto_state(1);
      ind_code = 4'd12;
      @(negedge clk);
      chk("R2 unstrobed code", 1, 0, 0, 0, 0);

      // exhaustive state x code sweep (R3 R4 R7 R8 R9 R10 R11 R12 R14)
      foreach (st_list[i]) begin
         for (int c = 0; c < 16; c++) begin
            goto_state(st_list[i]);
            step_ind(c);
            e = model(st_list[i], c);
            chk(tag_of(st_list[i], c), int'(e[10:7]), e[6], int'(e[5:2]), e[1], e[0]);
         end
      end

      // R5: requests outside F3 power-down, deactivate requests
      for (int i = 0; i < 8; i++) begin
         goto_state(st_list[i]);
         act_req = 1'b1;
         @(negedge clk);
         act_req = 1'b0;
         if (st_list[i] == 1) chk("R5 act request", 1, 1, 8, 0, 0);
         else                 chk("R5 act request ignored", st_list[i], 0, 0, 0, 0);
         deact_req = 1'b1;
         @(negedge clk);
         deact_req = 1'b0;
         chk("R5 deact request ignored", st_list[i], 0, 0, 0, 0);
      end

      // R6: expiry in every reachable state
      tmr_case(1, 1);
      tmr_case(4, 1);
      tmr_case(5, 1);
      tmr_case(6, 1);
      tmr_case(8, 1);
      tmr_case(3, 0);
      tmr_case(7, 0);
      tmr_case(0, 0);

      // R5 R6: a second request restarts the count
      do_reset();
      step_ind(15);
      act_pulse();
      quiet(5, "R5 restart window");
      act_pulse();
      chk("R5 restart command", 1, 1, 8, 0, 0);
      quiet(T - 1, "R5 restarted timer quiet");
      @(negedge clk);
      chk("R5 restarted expiry", 1, 1, 15, 0, 1);

      // R13: indication beats expiry in the same cycle
      do_reset();
      step_ind(15);
      act_pulse();
      step_ind(7);
      quiet(T - 2, "R13 pre-collision");
      step_ind(4);
      chk("R13 indication over expiry", 5, 0, 0, 0, 0);
      quiet(T, "R13 expiry discarded");

      // R13: indication beats activate request
      do_reset();
      step_ind(15);
      act_req = 1'b1;
      ind_valid = 1'b1;
      ind_code = 4'd7;
      @(negedge clk);
      act_req = 1'b0;
      ind_valid = 1'b0;
      chk("R13 indication over request", 4, 0, 0, 0, 0);
      quiet(T + 2, "R13 request discarded");

      // R13: expiry beats activate request
      do_reset();
      step_ind(15);
      act_pulse();
      quiet(T - 1, "R13 pre-collision 2");
      act_pulse();
      chk("R13 expiry over request", 1, 1, 15, 0, 1);
      quiet(T + 2, "R13 request lost to expiry");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule